// File: doc/BRIEF.md
# DDR2 Extended Mode Register Decoder

This block sits beside a DDR2 device model or memory-side controller and follows the command bus. It reacts to the mode-register-set command, which is chip select, row strobe, column strobe and write enable all sampled low at one clock edge. On that command the two bank address bits pick one of four mode registers, and the row address is captured into the chosen register. Each write is accepted only when all eight banks report precharged and the clock enable has been high on the previous edge and on the current one. After an accepted write, a recovery window of `TMRD` clocks follows, and any command issued inside it is refused.

The second extended register controls refresh. Its three low bits give a partial-array self-refresh code, which the block turns into an 8-bit mask of the banks whose contents survive. Bit 7 of that register gives the high-temperature refresh-rate flag. The register has no defined value at power-up, so both derived outputs stay inactive until the first accepted write to it. When self-refresh entry is signalled, each bank outside the current mask is flagged as lost. A write to the second or third extended register that sets a reserved bit raises a warning pulse.

Top module: `ddr2_emr_decoder`

## Requirements
- R1: A write happens only when cs_n, ras_n, cas_n and we_n are all low at one rising edge. If any of the four is high, no register changes. An accepted write shows on the register output one cycle after the edge.
- R2: The bank address picks the target register. 0 selects mr_base_o, 1 selects mr_ext1_o, 2 selects mr_ext2_o and 3 selects mr_ext3_o. The other three registers keep their values.
- R3: While ext2_valid_o is high, retain_mask_o (bit n is bank n) is set from mr_ext2_o[2:0]:

  | Code | Mask |
  |------|------|
  | 0 | 0xFF |
  | 1 | 0x0F |
  | 2 | 0x03 |
  | 3 | 0x01 |
  | 4 | 0xFC |
  | 5 | 0xF0 |
  | 6 | 0xC0 |
  | 7 | 0x80 |

- R4: While ext2_valid_o is high, hot_rate_o equals bit 7 of mr_ext2_o.
- R5: ext2_valid_o is low from reset until the first accepted write to register 2, and it then stays high. While it is low, retain_mask_o is 0 and hot_rate_o is 0.
- R6: A set command is refused in either of two cases: some bit of banks_idle_i is low, or cke_i was low at this edge or at the previous one. On a refusal, err_precond_o pulses high for one cycle after the edge and every register keeps its value.
- R7: An accepted write holds busy_o high for TMRD-1 cycles. Any command issued while busy_o is high is refused, with one exception: a cycle with chip select low and ras_n, cas_n and we_n all high is a no-operation and is ignored. A refused command pulses err_tmrd_o for one cycle after the edge, and no register changes. This check takes priority over R6.
- R8: warn_rsvd_o pulses for one cycle after an accepted write in either of two cases: register 2 with any address bit other than 0, 1, 2 or 7 set, or register 3 with any address bit set. The write still takes effect. Writes to registers 0 and 1 never warn.
- R9: At an edge where sref_enter_i is high, lost_o gains every bank that is outside the mask in effect before that edge. If ext2_valid_o is low, every bank is added. Bits of lost_o stay set until reset.
- R10: Any register can be written again at any later time, under the same conditions as the first write.
- R11: After reset, all four registers read 0 and every flag, busy_o, ext2_valid_o, retain_mask_o and lost_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cke_i | input | 1 | Device clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address; selects the target register |
| addr_i | input | ROW_W | Row address; the value written |
| banks_idle_i | input | 8 | Per-bank precharged status |
| sref_enter_i | input | 1 | Self-refresh entry strobe |
| mr_base_o | output | ROW_W | Register 0 contents |
| mr_ext1_o | output | ROW_W | Register 1 contents |
| mr_ext2_o | output | ROW_W | Register 2 contents |
| mr_ext3_o | output | ROW_W | Register 3 contents |
| ext2_valid_o | output | 1 | Register 2 has been written |
| retain_mask_o | output | 8 | Banks kept in self refresh |
| hot_rate_o | output | 1 | High-temperature refresh rate selected |
| busy_o | output | 1 | Recovery window active |
| err_precond_o | output | 1 | Pulse: write refused, banks not precharged or clock enable low |
| err_tmrd_o | output | 1 | Pulse: command refused inside the recovery window |
| warn_rsvd_o | output | 1 | Pulse: reserved bit set in a write |
| lost_o | output | 8 | Sticky mask of banks whose data is invalid |

## Verification
The properties assume that the bus inputs are stable around each rising edge and that reset drives everything to a known state before any command arrives. They also assume that banks_idle_i really does reflect the banks. They do not assume that a controller keeps to the recovery window or to the precondition rules, because those violations are exactly what the block reports. To stay inside these assumptions, the stimulus changes inputs only on falling edges. It holds all inputs at no-operation while the reset release is being synchronised. It then runs directed sequences, followed by a random mix that deliberately breaks the spacing, clock-enable and precharge rules.

// File: rtl/ddr2_mr_pkg.sv
package ddr2_mr_pkg;

  localparam int NUM_BANKS = 8;
  localparam int NUM_REGS  = 4;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_EXT1 = 2'd1,
    SEL_EXT2 = 2'd2,
    SEL_EXT3 = 2'd3
  } mr_sel_e;

  // partial-array code -> banks whose contents survive self refresh
  function automatic logic [NUM_BANKS-1:0] pasr_keep(input logic [2:0] code);
    logic [NUM_BANKS-1:0] m;
    case (code)
      3'd0:    m = 8'hFF;
      3'd1:    m = 8'h0F;
      3'd2:    m = 8'h03;
      3'd3:    m = 8'h01;
      3'd4:    m = 8'hFC;  // three-quarter setting, upper six banks
      3'd5:    m = 8'hF0;
      3'd6:    m = 8'hC0;
      default: m = 8'h80;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mr_cmd_decode.sv
module mr_cmd_decode
  import ddr2_mr_pkg::*;
(
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke_now,
  input  logic                 cke_prev,
  input  logic [NUM_BANKS-1:0] banks_idle,
  input  logic                 busy,
  output logic                 wr_go,
  output logic                 rej_precond,
  output logic                 rej_timing
);

  logic set_cmd;
  logic any_cmd;
  logic ready;

  always_comb begin
    set_cmd     = ~cs_n & ~ras_n & ~cas_n & ~we_n;
    any_cmd     = ~cs_n & ~(ras_n & cas_n & we_n);
    ready       = cke_now & cke_prev & (&banks_idle);
    rej_timing  = busy & any_cmd;
    wr_go       = ~busy & set_cmd & ready;
    rej_precond = ~busy & set_cmd & ~ready;
  end

endmodule

// File: rtl/mr_timer.sv
module mr_timer #(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int CW = (TMRD < 2) ? 1 : $clog2(TMRD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TMRD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = RELOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/mr_regfile.sv
module mr_regfile
  import ddr2_mr_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_go,
  input  mr_sel_e                        sel,
  input  logic [ROW_W-1:0]               wdata,
  output logic [NUM_REGS-1:0][ROW_W-1:0] regs,
  output logic                           ext2_seen
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic             en;
    logic [ROW_W-1:0] q;
    assign en = wr_go && (sel == mr_sel_e'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign regs[g] = q;
  end

  logic seen_q, seen_d;
  always_comb seen_d = seen_q | (wr_go && (sel == SEL_EXT2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  assign ext2_seen = seen_q;

endmodule

// File: rtl/pasr_ctl.sv
module pasr_ctl
  import ddr2_mr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           code,
  input  logic                 hot_bit,
  input  logic                 valid,
  input  logic                 sref,
  output logic [NUM_BANKS-1:0] keep,
  output logic                 hot,
  output logic [NUM_BANKS-1:0] lost
);

  logic [NUM_BANKS-1:0] lost_q, lost_d;

  always_comb begin
    keep   = valid ? pasr_keep(code) : '0;
    hot    = valid & hot_bit;
    lost_d = lost_q;
    if (sref) lost_d = lost_q | ~keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= '0;
    else        lost_q <= lost_d;
  end

  assign lost = lost_q;

endmodule

// File: rtl/ddr2_emr_decoder.sv
module ddr2_emr_decoder
  import ddr2_mr_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int TMRD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             cs_n_i,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             we_n_i,
  input  logic [1:0]       ba_i,
  input  logic [ROW_W-1:0] addr_i,
  input  logic [7:0]       banks_idle_i,
  input  logic             sref_enter_i,
  output logic [ROW_W-1:0] mr_base_o,
  output logic [ROW_W-1:0] mr_ext1_o,
  output logic [ROW_W-1:0] mr_ext2_o,
  output logic [ROW_W-1:0] mr_ext3_o,
  output logic             ext2_valid_o,
  output logic [7:0]       retain_mask_o,
  output logic             hot_rate_o,
  output logic             busy_o,
  output logic             err_precond_o,
  output logic             err_tmrd_o,
  output logic             warn_rsvd_o,
  output logic [7:0]       lost_o
);

  // bits of register 2 that carry meaning: code in 2:0, rate in 7
  localparam logic [ROW_W-1:0] EXT2_USED = ROW_W'(8'h87);
  localparam logic [ROW_W-1:0] EXT2_RSVD = ~EXT2_USED;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic cke_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cke_q <= 1'b0;
    else            cke_q <= cke_i;
  end

  logic wr_go, rej_precond, rej_timing, busy;
  mr_sel_e sel;
  assign sel = mr_sel_e'(ba_i);

  mr_cmd_decode u_dec (
    .cs_n        (cs_n_i),
    .ras_n       (ras_n_i),
    .cas_n       (cas_n_i),
    .we_n        (we_n_i),
    .cke_now     (cke_i),
    .cke_prev    (cke_q),
    .banks_idle  (banks_idle_i),
    .busy        (busy),
    .wr_go       (wr_go),
    .rej_precond (rej_precond),
    .rej_timing  (rej_timing)
  );

  mr_timer #(.TMRD(TMRD)) u_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (wr_go),
    .busy  (busy)
  );

  logic [NUM_REGS-1:0][ROW_W-1:0] regs;
  logic                           ext2_seen;

  mr_regfile #(.ROW_W(ROW_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_go     (wr_go),
    .sel       (sel),
    .wdata     (addr_i),
    .regs      (regs),
    .ext2_seen (ext2_seen)
  );

  pasr_ctl u_pasr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .code    (regs[SEL_EXT2][2:0]),
    .hot_bit (regs[SEL_EXT2][7]),
    .valid   (ext2_seen),
    .sref    (sref_enter_i),
    .keep    (retain_mask_o),
    .hot     (hot_rate_o),
    .lost    (lost_o)
  );

  // registered violation pulses
  logic errp_q, errp_d, errt_q, errt_d, warn_q, warn_d;
  always_comb begin
    errp_d = rej_precond;
    errt_d = rej_timing;
    warn_d = wr_go && (((sel == SEL_EXT2) && |(addr_i & EXT2_RSVD)) ||
                       ((sel == SEL_EXT3) && |addr_i));
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      errp_q <= 1'b0;
      errt_q <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      errp_q <= errp_d;
      errt_q <= errt_d;
      warn_q <= warn_d;
    end
  end

  assign mr_base_o     = regs[SEL_BASE];
  assign mr_ext1_o     = regs[SEL_EXT1];
  assign mr_ext2_o     = regs[SEL_EXT2];
  assign mr_ext3_o     = regs[SEL_EXT3];
  assign ext2_valid_o  = ext2_seen;
  assign busy_o        = busy;
  assign err_precond_o = errp_q;
  assign err_tmrd_o    = errt_q;
  assign warn_rsvd_o   = warn_q;

endmodule

// File: rtl/ddr2_emr_decoder_sva.sv
module ddr2_emr_decoder_sva #(
  parameter int ROW_W = 14,
  parameter int TMRD  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_go,
  input logic             cs_n_i,
  input logic             ras_n_i,
  input logic             cas_n_i,
  input logic             we_n_i,
  input logic [ROW_W-1:0] mr_base_o,
  input logic [ROW_W-1:0] mr_ext1_o,
  input logic [ROW_W-1:0] mr_ext2_o,
  input logic [ROW_W-1:0] mr_ext3_o,
  input logic             ext2_valid_o,
  input logic [7:0]       retain_mask_o,
  input logic             hot_rate_o,
  input logic             busy_o,
  input logic             err_precond_o,
  input logic             err_tmrd_o,
  input logic [7:0]       lost_o
);

  logic [4*ROW_W-1:0] all_regs;
  assign all_regs = {mr_base_o, mr_ext1_o, mr_ext2_o, mr_ext3_o};

  // R5: derived outputs inactive before register 2 is written
  p_invalid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext2_valid_o |-> (retain_mask_o == 8'h00 && !hot_rate_o));

  // R5: validity never drops once set
  p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext2_valid_o |=> ext2_valid_o);

  // R3: a valid mask always keeps 1, 2, 4, 6 or 8 banks
  p_mask_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext2_valid_o |-> ($countones(retain_mask_o) == 1 || $countones(retain_mask_o) == 2 ||
                      $countones(retain_mask_o) == 4 || $countones(retain_mask_o) == 6 ||
                      $countones(retain_mask_o) == 8));

  // R4: rate flag follows bit 7 of register 2
  p_hot_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext2_valid_o |-> (hot_rate_o == mr_ext2_o[7]));

  // R6: refused write leaves the registers untouched
  p_precond_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_precond_o |-> (all_regs == $past(all_regs)));

  // R7: command in the window leaves the registers untouched
  p_tmrd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmrd_o |-> (all_regs == $past(all_regs)));

  // R7: a set command during busy is always refused
  p_busy_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cs_n_i && !ras_n_i && !cas_n_i && !we_n_i) |=> err_tmrd_o);

  // R7: an accepted write opens the window when it is longer than one cycle
  if (TMRD > 1) begin : g_win
    p_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> busy_o);
  end

  // R9: lost banks never come back
  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lost_o) & ~lost_o) == 8'h00);

endmodule

bind ddr2_emr_decoder ddr2_emr_decoder_sva #(.ROW_W(ROW_W), .TMRD(TMRD)) u_sva (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .wr_go         (wr_go),
  .cs_n_i        (cs_n_i),
  .ras_n_i       (ras_n_i),
  .cas_n_i       (cas_n_i),
  .we_n_i        (we_n_i),
  .mr_base_o     (mr_base_o),
  .mr_ext1_o     (mr_ext1_o),
  .mr_ext2_o     (mr_ext2_o),
  .mr_ext3_o     (mr_ext3_o),
  .ext2_valid_o  (ext2_valid_o),
  .retain_mask_o (retain_mask_o),
  .hot_rate_o    (hot_rate_o),
  .busy_o        (busy_o),
  .err_precond_o (err_precond_o),
  .err_tmrd_o    (err_tmrd_o),
  .lost_o        (lost_o)
);

// File: tb/ddr2_emr_decoder_test.sv
`timescale 1ns/1ps
module ddr2_emr_decoder_test;

  localparam int RW   = 14;
  localparam int TM   = 2;
  localparam int WDOG = 200000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]    ba = '0;
  logic [RW-1:0] addr = '0;
  logic [7:0]    idle = 8'hFF;
  logic          sref = 1'b0;

  logic [RW-1:0] mr0, mr1, mr2, mr3;
  logic          v2, hot, busy, errp, errt, warn;
  logic [7:0]    keep, lost;

  ddr2_emr_decoder uut (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
    .banks_idle_i(idle), .sref_enter_i(sref),
    .mr_base_o(mr0), .mr_ext1_o(mr1), .mr_ext2_o(mr2), .mr_ext3_o(mr3),
    .ext2_valid_o(v2), .retain_mask_o(keep), .hot_rate_o(hot), .busy_o(busy),
    .err_precond_o(errp), .err_tmrd_o(errt), .warn_rsvd_o(warn), .lost_o(lost)
  );

  int vectors = 0;
  int fails   = 0;

  // reference model state
  logic [RW-1:0] m_mr [4];
  logic          m_v2, m_ckeq, m_errp, m_errt, m_warn;
  logic [7:0]    m_lost;
  int            m_cnt;

  function automatic logic [7:0] kept_banks(input logic [2:0] c);
    logic [7:0] m = 8'h00;
    int n;
    if (c < 3'd4) begin
      n = 8 >> c;
      for (int b = 0; b < 8; b++) if (b < n) m[b] = 1'b1;
    end else begin
      n = (c == 3'd4) ? 6 : (c == 3'd5) ? 4 : (c == 3'd6) ? 2 : 1;
      for (int b = 0; b < 8; b++) if (b >= 8 - n) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [7:0] m_keep();
    return m_v2 ? kept_banks(m_mr[2][2:0]) : 8'h00;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) m_mr[i] = '0;
    m_v2 = 0; m_ckeq = 0; m_errp = 0; m_errt = 0; m_warn = 0;
    m_lost = '0; m_cnt = 0;
  endtask

  task automatic model_edge();
    logic [7:0] k;
    logic is_set, is_cmd;
    bit wrote;
    k      = m_keep();
    is_set = !cs_n && !ras_n && !cas_n && !we_n;
    is_cmd = !cs_n && !(ras_n && cas_n && we_n);
    wrote  = 0;
    m_errp = 0; m_errt = 0; m_warn = 0;
    if (m_cnt > 0 && is_cmd) m_errt = 1;
    else if (is_set) begin
      if (cke && m_ckeq && idle == 8'hFF) begin
        wrote = 1;
        m_mr[ba] = addr;
        if (ba == 2'd2) begin
          m_v2 = 1;
          if ((addr & ~RW'(14'h0087)) != 0) m_warn = 1;
        end
        if (ba == 2'd3 && addr != 0) m_warn = 1;
      end else m_errp = 1;
    end
    if (wrote) m_cnt = TM - 1;
    else if (m_cnt > 0) m_cnt--;
    if (sref) m_lost = m_lost | ~k;
    m_ckeq = cke;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({"R1/R2 base ", tag}, 32'(mr0), 32'(m_mr[0]));
    chk({"R1/R2 ext1 ", tag}, 32'(mr1), 32'(m_mr[1]));
    chk({"R1/R2 ext2 ", tag}, 32'(mr2), 32'(m_mr[2]));
    chk({"R1/R2 ext3 ", tag}, 32'(mr3), 32'(m_mr[3]));
    chk({"R5 valid ", tag},   32'(v2),  32'(m_v2));
    chk({"R3 mask ", tag},    32'(keep), 32'(m_keep()));
    chk({"R4 hot ", tag},     32'(hot), 32'(m_v2 && m_mr[2][7]));
    chk({"R7 busy ", tag},    32'(busy), 32'(m_cnt > 0));
    chk({"R7 err_tmrd ", tag}, 32'(errt), 32'(m_errt));
    chk({"R6 err_precond ", tag}, 32'(errp), 32'(m_errp));
    chk({"R8 warn ", tag},    32'(warn), 32'(m_warn));
    chk({"R9 lost ", tag},    32'(lost), 32'(m_lost));
  endtask

  task automatic nop();
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; sref = 0;
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step(input string tag, input bit hold = 0);
    @(posedge clk);
    if (hold) model_clear(); else model_edge();
    @(negedge clk);
    compare(tag);
    nop();
  endtask

  task automatic gap(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic set_cmd(input logic [1:0] b, input logic [RW-1:0] a, input string tag);
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; ba = b; addr = a;
    step(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; nop(); cke = 0; model_clear();
    for (int i = 0; i < 3; i++) step("R11 reset", 1);
    rst_n = 1;
    for (int i = 0; i < 2; i++) step("R11 release", 1);
    cke = 1;
    gap(2, "R11 idle");
  endtask

  initial begin
    #(WDOG * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();

    // R5/R9: self-refresh before register 2 is written loses every bank
    sref = 1; step("R9 sref unwritten");
    gap(1, "R9");
    do_reset();

    // R1/R2: each register by bank address
    set_cmd(2'd0, 14'h0123, "R2 base"); gap(2, "R2");
    set_cmd(2'd1, 14'h0456, "R2 ext1"); gap(2, "R2");
    set_cmd(2'd2, 14'h0080, "R2 ext2"); gap(2, "R2");
    set_cmd(2'd3, 14'h0000, "R2 ext3"); gap(2, "R2");

    // R1: one strobe high means no write
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = 1; ba = 2'd0; addr = 14'h3FFF;
    step("R1 we high"); gap(2, "R1");
    cs_n = 1; ras_n = 0; cas_n = 0; we_n = 0; ba = 2'd1; addr = 14'h3FFF;
    step("R1 cs high"); gap(2, "R1");

    // R3/R4: every code, rate bit alternating; R10 rewrites
    for (int c = 0; c < 8; c++) begin
      set_cmd(2'd2, RW'(c) | ((c % 2 == 1) ? RW'(14'h0080) : RW'(0)), "R3/R4/R10 code");
      gap(2, "R3");
    end

    // R7: back-to-back commands
    set_cmd(2'd1, 14'h0011, "R7 first");
    set_cmd(2'd1, 14'h0022, "R7 second in window");
    gap(2, "R7");
    set_cmd(2'd0, 14'h0033, "R7 first");
    cs_n = 0; ras_n = 0; cas_n = 1; we_n = 1; step("R7 row command in window");
    gap(2, "R7");

    // R6: bank open, clock enable low now, clock enable low previously
    idle = 8'hF7; set_cmd(2'd1, 14'h0100, "R6 bank open");
    idle = 8'hFF; gap(2, "R6");
    cke = 0; set_cmd(2'd1, 14'h0200, "R6 cke low");
    cke = 1; set_cmd(2'd1, 14'h0300, "R6 cke just raised");
    gap(2, "R6");
    set_cmd(2'd1, 14'h0400, "R6/R10 accepted after");
    gap(2, "R6");

    // R8: reserved bits
    set_cmd(2'd2, 14'h0024, "R8 ext2 bit5"); gap(2, "R8");
    set_cmd(2'd2, 14'h2083, "R8 ext2 bit13"); gap(2, "R8");
    set_cmd(2'd3, 14'h0001, "R8 ext3 nonzero"); gap(2, "R8");
    set_cmd(2'd1, 14'h3FFF, "R8 ext1 no warn"); gap(2, "R8");
    set_cmd(2'd0, 14'h3FFF, "R8 base no warn"); gap(2, "R8");

    // R9: self-refresh with partial masks
    do_reset();
    set_cmd(2'd2, 14'h0005, "R9 upper half"); gap(2, "R9");
    sref = 1; step("R9 sref half"); gap(2, "R9");
    set_cmd(2'd2, 14'h0004, "R9 three quarter"); gap(2, "R9");
    sref = 1; step("R9 sref 3/4"); gap(2, "R9");
    set_cmd(2'd2, 14'h0003, "R9 one eighth"); gap(2, "R9");
    sref = 1; step("R9 sref 1/8"); gap(2, "R9");

    // random mix
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 4;
      if (r == 0) begin cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; end
      else if (r == 1) begin
        cs_n = 0; ras_n = 1'($urandom); cas_n = 1'($urandom); we_n = 1'($urandom);
      end
      ba   = 2'($urandom);
      addr = RW'($urandom);
      cke  = ($urandom % 16) != 0;
      idle = (($urandom % 8) == 0) ? 8'($urandom) : 8'hFF;
      sref = ($urandom % 40) == 0;
      step("R1..random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule